// File: doc/BRIEF.md
# ADC Scan-Mode Channel Sequencer

This block drives an analog-to-digital converter core in continuous scan mode. Software programs a control word that holds a run bit, a group bit, a two-bit channel-count field and an interrupt enable. The run bit can also be set by a timer pulse or by an external trigger pulse. While the run bit is 1, the sequencer starts conversions on a run of consecutive channels. The run begins at the group's first channel, which is channel 0 for group 0 and channel 4 for group 1. The sequencer presents the channel index and a one-cycle start strobe to the converter, then waits for the converter's done pulse and its result.

Each result is written into that channel's own data register. As soon as a result is taken, the next channel is started. When the last channel of a pass completes, an end-of-scan flag is set and the sequence wraps back to the group's first channel. The scan repeats until software clears the run bit. The flag stays set until software clears it. The interrupt request is the flag gated by the enable bit.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, the run state, the end-of-scan flag, the interrupt request and the start strobe are 0, and every result register reads 0.
- R2: A control write with the run field 1, or a one-cycle pulse on the timer or external trigger input, sets the run state. The first start strobe appears one cycle after the run state reads 1. It carries the channel index 4 × group (0 for group 0, 4 for group 1).
- R3: A count field value c (0 to 3) scans c+1 channels, from base to base+c, in ascending order.
- R4: When a done pulse is accepted while running, the start strobe for the next channel is high in the very next cycle. The strobe is a single-cycle pulse.
- R5: The result carried with an accepted done pulse appears in that channel's result register one cycle later. All other result registers keep their values. Register i occupies bits i×DATA_W upward on the result bus.
- R6: The done pulse of a pass's last channel sets the end-of-scan flag in the next cycle, and the next start strobe selects the base channel again.
- R7: The interrupt request is 1 exactly when the flag is 1 and the enable bit of the last control write is 1.
- R8: The flag holds until a clear pulse is given. A flag set and a clear pulse in the same cycle leave the flag at 1.
- R9: Once the run state reads 0, the sequencer issues no start strobe from the next cycle on. A done pulse arriving then is discarded: no result register changes and the flag is not set.
- R10: After a stop, setting the run bit again restarts the scan at the group's base channel, not at the channel where it stopped.
- R11: Group and count are captured when a scan starts. A control write that changes them in the same cycle as it sets the run bit applies them to that scan. A write while the scan is running does not change that scan's order.
- R12: A trigger pulse while the run state is already 1 has no effect on the channel order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe; loads all cfg_* fields |
| cfg_run | input | 1 | Run bit value to write |
| cfg_group | input | GRP_W | Channel group select |
| cfg_count | input | CNT_W | Channel count minus one |
| cfg_irq_en | input | 1 | Interrupt enable |
| trig_timer | input | 1 | Timer trigger pulse; sets run bit |
| trig_ext | input | 1 | External trigger pulse; sets run bit |
| flag_clr | input | 1 | Clears end-of-scan flag |
| conv_done | input | 1 | Converter finished pulse |
| conv_data | input | DATA_W | Converter result |
| conv_start | output | 1 | Start strobe to converter |
| conv_chan | output | CH_W | Channel mux select |
| run_state | output | 1 | Current run bit |
| eoc_flag | output | 1 | End-of-scan flag |
| irq | output | 1 | Interrupt request |
| res_flat | output | NUM_CH*DATA_W | All result registers, channel 0 in the low bits |

## Verification
Every group and count combination is swept for two full passes. Each conversion gets a result computed from its channel and pass number, so a value written to the wrong register or left stale from an earlier pass shows up. Further runs stop the scan at different points and restart it: they tell a restart from base apart from a resume, and a discarded result apart from a stored one. Trigger pulses and control writes are also applied during a running scan, along with a flag clear that coincides with a flag set, to separate captured settings from live ones and to confirm that set wins over clear.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_e;

endpackage

// File: rtl/adc_scan_rst_sync.sv
module adc_scan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int GRP_W = 1,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_run,
  input  logic [GRP_W-1:0] cfg_group,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_irq_en,
  input  logic             trig_any,
  output logic             run_q,
  output logic [GRP_W-1:0] grp_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ie_q
);

  logic             run_d;
  logic [GRP_W-1:0] grp_d;
  logic [CNT_W-1:0] cnt_d;
  logic             ie_d;

  // Software write has priority over a trigger in the same cycle.
  always_comb begin
    run_d = run_q;
    grp_d = grp_q;
    cnt_d = cnt_q;
    ie_d  = ie_q;
    if (cfg_we) begin
      run_d = cfg_run;
      grp_d = cfg_group;
      cnt_d = cfg_count;
      ie_d  = cfg_irq_en;
    end else if (trig_any) begin
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      grp_q <= '0;
      cnt_q <= '0;
      ie_q  <= 1'b0;
    end else begin
      run_q <= run_d;
      grp_q <= grp_d;
      cnt_q <= cnt_d;
      ie_q  <= ie_d;
    end
  end

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int GROUP_CH = 4,
  parameter int GRP_W    = 1,
  parameter int CNT_W    = 2,
  parameter int CH_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [GRP_W-1:0] grp,
  input  logic [CNT_W-1:0] cnt,
  input  logic             conv_done,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  output logic             busy,
  output logic [CNT_W-1:0] cnt_act,
  output logic             wr_en,
  output logic [CH_W-1:0]  wr_chan,
  output logic             pass_end
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] off_q, off_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0]  base_q, base_d;
  logic             start_q, start_d;
  logic [CH_W-1:0]  base_new;

  assign base_new = CH_W'(grp) * CH_W'(GROUP_CH);

  always_comb begin
    state_d  = state_q;
    off_d    = off_q;
    cnt_d    = cnt_q;
    base_d   = base_q;
    start_d  = 1'b0;
    wr_en    = 1'b0;
    pass_end = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (run) begin
          state_d = SEQ_BUSY;
          off_d   = '0;
          cnt_d   = cnt;
          base_d  = base_new;
          start_d = 1'b1;
        end
      end
      SEQ_BUSY: begin
        if (!run) begin
          state_d = SEQ_IDLE;
        end else if (conv_done) begin
          wr_en   = 1'b1;
          start_d = 1'b1;
          if (off_q == cnt_q) begin
            off_d    = '0;
            pass_end = 1'b1;
          end else begin
            off_d = off_q + 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      off_q   <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      off_q   <= off_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      start_q <= start_d;
    end
  end

  assign conv_start = start_q;
  assign conv_chan  = base_q + CH_W'(off_q);
  assign wr_chan    = conv_chan;
  assign busy       = (state_q == SEQ_BUSY);
  assign cnt_act    = cnt_q;

endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 10,
  parameter int CH_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          wr_chan,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_CH*DATA_W-1:0] res_flat
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [DATA_W-1:0] data_q;
    logic              load;

    assign load = wr_en && (wr_chan == CH_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
      end else if (load) begin
        data_q <= wr_data;
      end
    end

    assign res_flat[i*DATA_W +: DATA_W] = data_q;
  end

endmodule

// File: rtl/adc_scan_flag.sv
module adc_scan_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);

  logic flag_q, flag_d;

  // Set wins over clear.
  always_comb begin
    flag_d = flag_q;
    if (set) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
  assign irq  = flag_q & irq_en;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int DATA_W     = 10,
  parameter int GROUP_CH   = 4,
  parameter int NUM_GROUPS = 2,
  localparam int NUM_CH    = GROUP_CH * NUM_GROUPS,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W     = (GROUP_CH > 1) ? $clog2(GROUP_CH) : 1,
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_run,
  input  logic [GRP_W-1:0]         cfg_group,
  input  logic [CNT_W-1:0]         cfg_count,
  input  logic                     cfg_irq_en,
  input  logic                     trig_timer,
  input  logic                     trig_ext,
  input  logic                     flag_clr,
  input  logic                     conv_done,
  input  logic [DATA_W-1:0]        conv_data,
  output logic                     conv_start,
  output logic [CH_W-1:0]          conv_chan,
  output logic                     run_state,
  output logic                     eoc_flag,
  output logic                     irq,
  output logic [NUM_CH*DATA_W-1:0] res_flat
);

  logic             rst_sync_n;
  logic             run_q;
  logic [GRP_W-1:0] grp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ie_q;
  logic             busy;
  logic [CNT_W-1:0] cnt_act;
  logic             wr_en;
  logic [CH_W-1:0]  wr_chan;
  logic             pass_end;

  adc_scan_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adc_scan_ctrl #(.GRP_W(GRP_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_we     (cfg_we),
    .cfg_run    (cfg_run),
    .cfg_group  (cfg_group),
    .cfg_count  (cfg_count),
    .cfg_irq_en (cfg_irq_en),
    .trig_any   (trig_timer | trig_ext),
    .run_q      (run_q),
    .grp_q      (grp_q),
    .cnt_q      (cnt_q),
    .ie_q       (ie_q)
  );

  adc_scan_fsm #(
    .GROUP_CH (GROUP_CH),
    .GRP_W    (GRP_W),
    .CNT_W    (CNT_W),
    .CH_W     (CH_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .run        (run_q),
    .grp        (grp_q),
    .cnt        (cnt_q),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .busy       (busy),
    .cnt_act    (cnt_act),
    .wr_en      (wr_en),
    .wr_chan    (wr_chan),
    .pass_end   (pass_end)
  );

  adc_scan_results #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .wr_chan  (wr_chan),
    .wr_data  (conv_data),
    .res_flat (res_flat)
  );

  adc_scan_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set    (pass_end),
    .clr    (flag_clr),
    .irq_en (ie_q),
    .flag   (eoc_flag),
    .irq    (irq)
  );

  assign run_state = run_q;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CNT_W = 2,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             busy,
  input logic [CNT_W-1:0] cnt_act,
  input logic             conv_start,
  input logic             conv_done,
  input logic [CH_W-1:0]  conv_chan,
  input logic             eoc_flag,
  input logic             flag_clr,
  input logic             irq
);

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start && !conv_done |=> !conv_start);

  // R4
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && run_q && conv_done |=> conv_start);

  // R9
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !conv_start);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_flag && !flag_clr |=> eoc_flag);

  // R6
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_flag) |-> $past(conv_done && run_q && busy));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> eoc_flag);

  // R3
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_chan[CNT_W-1:0] <= cnt_act));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CNT_W(CNT_W), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .run_q      (run_q),
  .busy       (busy),
  .cnt_act    (cnt_act),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .conv_chan  (conv_chan),
  .eoc_flag   (eoc_flag),
  .flag_clr   (flag_clr),
  .irq        (irq)
);

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;

  localparam int DW = 10;
  localparam int NCH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_run = 1'b0, cfg_irq_en = 1'b0;
  logic [0:0]    cfg_group = '0;
  logic [1:0]    cfg_count = '0;
  logic          trig_timer = 1'b0, trig_ext = 1'b0, flag_clr = 1'b0;
  logic          conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic          conv_start;
  logic [2:0]    conv_chan;
  logic          run_state, eoc_flag, irq;
  logic [NCH*DW-1:0] res_flat;

  int checks = 0;
  int fails  = 0;
  int exp_res [NCH];

  always #2.5 clk = ~clk;

  adc_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_run(cfg_run),
    .cfg_group(cfg_group), .cfg_count(cfg_count), .cfg_irq_en(cfg_irq_en),
    .trig_timer(trig_timer), .trig_ext(trig_ext), .flag_clr(flag_clr),
    .conv_done(conv_done), .conv_data(conv_data), .conv_start(conv_start),
    .conv_chan(conv_chan), .run_state(run_state), .eoc_flag(eoc_flag),
    .irq(irq), .res_flat(res_flat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int res_of(input int ch);
    return int'(res_flat[ch*DW +: DW]);
  endfunction

  function automatic int mkdata(input int ch, input int pass, input int salt);
    return (ch * 37 + pass * 101 + salt * 13 + 1) % 1024;
  endfunction

  task automatic check_all_res(input string req);
    for (int i = 0; i < NCH; i++) check(res_of(i) == exp_res[i], req, res_of(i), exp_res[i]);
  endtask

  task automatic write_cfg(input bit run, input int grp, input int cnt, input bit ie);
    @(negedge clk);
    cfg_we = 1'b1; cfg_run = run; cfg_group = grp[0:0]; cfg_count = cnt[1:0]; cfg_irq_en = ie;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_start(input string req);
    int n = 0;
    while (!conv_start && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(conv_start == 1'b1, req, int'(conv_start), 1);
  endtask

  // Converter model: done pulse after a short latency; optional flag clear in the same cycle.
  task automatic convert(input int d, input bit clr);
    repeat (2) @(negedge clk);
    conv_done = 1'b1; conv_data = d[DW-1:0]; flag_clr = clr;
    @(negedge clk);
    conv_done = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic pulse_clr;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) exp_res[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(run_state == 1'b0, "R1 run", int'(run_state), 0);
    check(eoc_flag == 1'b0, "R1 flag", int'(eoc_flag), 0);
    check(irq == 1'b0, "R1 irq", int'(irq), 0);
    check(conv_start == 1'b0, "R1 start", int'(conv_start), 0);
    check_all_res("R1 results");

    // R2 R3 R4 R5 R6 R7 R8: sweep groups and counts, two passes each
    for (int g = 0; g < 2; g++) begin
      for (int c = 0; c < 4; c++) begin
        write_cfg(1'b1, g, c, 1'b1);
        wait_start("R2 first start");
        for (int p = 0; p < 2; p++) begin
          for (int k = 0; k <= c; k++) begin
            int d;
            check(int'(conv_chan) == g * 4 + k, "R2 R3 channel", int'(conv_chan), g * 4 + k);
            d = mkdata(g * 4 + k, p, c);
            convert(d, 1'b0);
            exp_res[g * 4 + k] = d;
            check(conv_start == 1'b1, "R4 no gap", int'(conv_start), 1);
            check_all_res("R5 result");
            if (k == c) begin
              check(eoc_flag == 1'b1, "R6 flag set", int'(eoc_flag), 1);
              check(irq == 1'b1, "R7 irq", int'(irq), 1);
              check(int'(conv_chan) == g * 4, "R6 wrap", int'(conv_chan), g * 4);
              pulse_clr();
              check(eoc_flag == 1'b0, "R8 clear", int'(eoc_flag), 0);
              check(irq == 1'b0, "R7 irq low", int'(irq), 0);
            end else begin
              check(eoc_flag == 1'b0, "R6 flag mid", int'(eoc_flag), 0);
            end
          end
        end
        write_cfg(1'b0, g, c, 1'b1);
        repeat (3) @(negedge clk);
      end
    end

    // R9 stop then a late done is discarded
    write_cfg(1'b1, 0, 3, 1'b1);
    wait_start("R9 start");
    convert(mkdata(0, 7, 7), 1'b0);
    exp_res[0] = mkdata(0, 7, 7);
    check(int'(conv_chan) == 1, "R3 next", int'(conv_chan), 1);
    write_cfg(1'b0, 0, 3, 1'b1);
    conv_done = 1'b1; conv_data = 10'h3AA;
    @(negedge clk);
    conv_done = 1'b0;
    check_all_res("R9 discard");
    check(eoc_flag == 1'b0, "R9 no flag", int'(eoc_flag), 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(conv_start == 1'b0, "R9 quiet", int'(conv_start), 0);
    end

    // R10 restart begins at base
    write_cfg(1'b1, 0, 2, 1'b1);
    wait_start("R10 restart");
    check(int'(conv_chan) == 0, "R10 base", int'(conv_chan), 0);
    convert(mkdata(0, 8, 0), 1'b0);
    exp_res[0] = mkdata(0, 8, 0);
    check(int'(conv_chan) == 1, "R10 step", int'(conv_chan), 1);
    write_cfg(1'b0, 0, 2, 1'b1);
    write_cfg(1'b1, 0, 2, 1'b1);
    wait_start("R10 restart 2");
    check(int'(conv_chan) == 0, "R10 from base", int'(conv_chan), 0);

    // R12 trigger while running is ignored
    @(negedge clk); trig_ext = 1'b1;
    @(negedge clk); trig_ext = 1'b0;
    convert(mkdata(0, 9, 0), 1'b0);
    exp_res[0] = mkdata(0, 9, 0);
    check(int'(conv_chan) == 1, "R12 order kept", int'(conv_chan), 1);

    // R11 write during a scan does not alter it
    write_cfg(1'b1, 1, 0, 1'b0);
    convert(mkdata(1, 9, 0), 1'b0);
    exp_res[1] = mkdata(1, 9, 0);
    check(int'(conv_chan) == 2, "R11 old order", int'(conv_chan), 2);
    check_all_res("R11 results");

    // R11 new settings apply after stop; timer trigger restarts
    write_cfg(1'b0, 1, 0, 1'b0);
    repeat (2) @(negedge clk);
    @(negedge clk); trig_timer = 1'b1;
    @(negedge clk); trig_timer = 1'b0;
    check(run_state == 1'b1, "R2 timer sets run", int'(run_state), 1);
    wait_start("R2 timer start");
    check(int'(conv_chan) == 4, "R11 new group", int'(conv_chan), 4);

    // R8 set wins over clear; R7 enable off
    convert(mkdata(4, 9, 1), 1'b1);
    exp_res[4] = mkdata(4, 9, 1);
    check(eoc_flag == 1'b1, "R8 set wins", int'(eoc_flag), 1);
    check(irq == 1'b0, "R7 irq masked", int'(irq), 0);
    check(int'(conv_chan) == 4, "R6 single wrap", int'(conv_chan), 4);
    check(conv_start == 1'b1, "R4 single no gap", int'(conv_start), 1);
    check_all_res("R5 group1");

    write_cfg(1'b0, 1, 0, 1'b0);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule